// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between an 8-bit processor core and external program and data memory. The core supplies a 16-bit address and says whether the access is an instruction fetch, a data read or a data write. The block then runs one four-clock machine cycle on two shared 8-bit ports, here called the low port and the high port. It drives an address latch enable strobe for an external latch, an active-low program-store enable for fetches, and active-low read and write strobes for data. When the cycle ends it returns the read byte and a one-clock done pulse.

Three bus arrangements split address and data across the two ports in different ways. In the plain arrangement the high port holds the upper address byte for the whole cycle, and the low port carries the lower address byte and then the data. In the first paged arrangement the low port carries only data, and the high port shows the lower address byte and then the upper address byte. In the second paged arrangement the low port holds only the lower address byte, and the high port carries the upper address byte and then the data.

Each port has a separate output value, output enable and input. An external pad ring combines these into a tri-state pin.

Top module: `xmb_bus`

## Requirements
- R1: While `req_ready` is high and `req_valid` is high at a rising edge, the request is taken. `req_ready` then goes low and stays low until the access has ended. In the first clock after acceptance `ale` is high. While `req_ready` is low, `req_valid` is ignored.
- R2: Plain arrangement (`mode_cfg` 00, and also 11). In all four phases the high port drives address bits 15:8. In phases 0 and 1 the low port drives address bits 7:0. In phases 2 and 3 the low port is the data port.
- R3: First paged arrangement (`mode_cfg` 01). In phases 0 and 1 the low port is released. In phases 2 and 3 the low port is the data port. The high port drives address bits 7:0 in phases 0 and 1, and address bits 15:8 in phases 2 and 3.
- R4: Second paged arrangement (`mode_cfg` 10). In all four phases the low port drives address bits 7:0. The high port drives address bits 15:8 in phases 0 and 1, and is the data port in phases 2 and 3.
- R5: `ale` is high only in phase 0, which is the first clock after acceptance. Both ports keep their value and their enable from phase 0 into phase 1, so the latch enable falls before any port changes over to data.
- R6: In phases 2 and 3 exactly one strobe is low. `psen_n` is low for a fetch. `wr_n` is low for a data write. `rd_n` is low for a data read. If `req_fetch` is high, the access is a fetch whatever the value of `req_write`. No strobe is low while `ale` is high.
- R7: In phases 2 and 3 of a write, the data port drives `req_wdata`. In phases 2 and 3 of a fetch or a read, the data port is released and drives the value 0. The block samples the data port input at the rising edge that ends phase 3. `rsp_rdata` keeps that byte until the next fetch or read completes, and a write leaves it unchanged.
- R8: `rsp_done` is high for exactly one clock, in the clock after phase 3. In that clock `req_ready` is high, and a new request can be accepted at the end of that same clock.
- R9: The arrangement, address, write data and access kind are captured at acceptance. Changes to `mode_cfg` or to the request inputs during an access have no effect on that access.
- R10: After reset the block is idle: `req_ready` is 1, `ale` is 0, all three active-low strobes are 1, both output enables are 0, both port outputs are 0, `rsp_done` is 0 and `rsp_rdata` is 0. All of this except `rsp_done` and `rsp_rdata` holds in every idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_cfg | input | 2 | Bus arrangement select, from a control register |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_write | input | 1 | Data access is a write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Last byte fetched or read |
| rsp_done | output | 1 | One-clock end-of-access pulse |
| lo_port_o | output | 8 | Low port output value |
| lo_port_oe | output | 1 | Low port output enable |
| lo_port_i | input | 8 | Low port input value |
| hi_port_o | output | 8 | High port output value |
| hi_port_oe | output | 1 | High port output enable |
| hi_port_i | input | 8 | High port input value |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The done pulse of one access and the acceptance of the next request can fall in the same clock. The bench provokes this by presenting a new request in the done cycle of the previous one, with a random arrangement and access kind. It judges the result by checking that `rsp_done`, `req_ready` and the returned byte are correct in that clock, and that `ale` appears in the very next clock with the new address on the ports. A second overlap is a request presented while an access is still running, together with a change of arrangement. The bench checks that neither one disturbs the running cycle, and that no latch enable follows the done pulse.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 2 * DATA_W;
    localparam int unsigned MC_CLKS = 4;
    localparam int unsigned PH_W    = $clog2(MC_CLKS);

    localparam logic [PH_W-1:0] PH_ALE  = PH_W'(0);
    localparam logic [PH_W-1:0] PH_STB  = PH_W'(2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_CLKS - 1);

    typedef enum logic [1:0] {
        BM_PLAIN  = 2'd0,
        BM_PAGE_A = 2'd1,
        BM_PAGE_B = 2'd2
    } bus_mode_e;

    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        bus_mode_e           mode;
        acc_kind_e           kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } xreq_t;

    typedef struct packed {
        logic                oe;
        logic [DATA_W-1:0]   val;
    } lane_t;

    function automatic bus_mode_e decode_mode(input logic [1:0] cfg);
        case (cfg)
            2'b01:   return BM_PAGE_A;
            2'b10:   return BM_PAGE_B;
            default: return BM_PLAIN;
        endcase
    endfunction

    function automatic acc_kind_e classify(input logic fetch, input logic write);
        if (fetch)      return K_FETCH;
        else if (write) return K_WRITE;
        else            return K_READ;
    endfunction

    // the port that carries the data byte during the strobe phases
    function automatic logic data_on_hi(input bus_mode_e m);
        return (m == BM_PAGE_B);
    endfunction

    function automatic lane_t lane_drive(input xreq_t r,
                                         input logic [PH_W-1:0] ph,
                                         input logic is_hi);
        lane_t addr_hi;
        lane_t addr_lo;
        lane_t dat;
        logic  addr_ph;
        addr_hi = '{oe: 1'b1, val: r.addr[ADDR_W-1:DATA_W]};
        addr_lo = '{oe: 1'b1, val: r.addr[DATA_W-1:0]};
        dat     = (r.kind == K_WRITE) ? '{oe: 1'b1, val: r.wdata} : '0;
        addr_ph = (ph < PH_STB);
        case (r.mode)
            BM_PAGE_A: begin
                if (is_hi) return addr_ph ? addr_lo : addr_hi;
                else       return addr_ph ? lane_t'('0) : dat;
            end
            BM_PAGE_B: begin
                if (is_hi) return addr_ph ? addr_hi : dat;
                else       return addr_lo;
            end
            default: begin
                if (is_hi) return addr_hi;
                else       return addr_ph ? addr_lo : dat;
            end
        endcase
    endfunction

endpackage

// File: rtl/xmb_seq.sv
module xmb_seq
    import xmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  xreq_t               req_in,
    output logic                busy,
    output logic [PH_W-1:0]     phase,
    output xreq_t               cur,
    output logic                done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= '0;
            cur   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    busy  <= 1'b1;
                    phase <= PH_ALE;
                    cur   <= req_in;
                end
            end else if (phase == PH_LAST) begin
                busy  <= 1'b0;
                phase <= '0;
                done  <= 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xmb_lanes.sv
module xmb_lanes
    import xmb_pkg::*;
(
    input  logic                busy,
    input  logic [PH_W-1:0]     phase,
    input  xreq_t               cur,
    output lane_t               lo_lane,
    output lane_t               hi_lane
);

    lane_t lanes [2];

    for (genvar i = 0; i < 2; i++) begin : g_lane
        assign lanes[i] = busy ? lane_drive(cur, phase, (i == 1)) : lane_t'('0);
    end

    assign lo_lane = lanes[0];
    assign hi_lane = lanes[1];

endmodule

// File: rtl/xmb_strobe.sv
module xmb_strobe
    import xmb_pkg::*;
(
    input  logic                busy,
    input  logic [PH_W-1:0]     phase,
    input  acc_kind_e           kind,
    output logic                ale,
    output logic                psen_n,
    output logic                rd_n,
    output logic                wr_n
);

    logic stb_win;

    always_comb begin
        stb_win = busy && (phase >= PH_STB);
        ale     = busy && (phase == PH_ALE);
        psen_n  = !(stb_win && (kind == K_FETCH));
        rd_n    = !(stb_win && (kind == K_READ));
        wr_n    = !(stb_win && (kind == K_WRITE));
    end

endmodule

// File: rtl/xmb_bus.sv
module xmb_bus
    import xmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_cfg,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_fetch,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   lo_port_o,
    output logic                lo_port_oe,
    input  logic [DATA_W-1:0]   lo_port_i,
    output logic [DATA_W-1:0]   hi_port_o,
    output logic                hi_port_oe,
    input  logic [DATA_W-1:0]   hi_port_i,
    output logic                ale,
    output logic                psen_n,
    output logic                rd_n,
    output logic                wr_n
);

    xreq_t              req_in;
    xreq_t              cur;
    logic               busy;
    logic [PH_W-1:0]    phase;
    lane_t              lo_lane;
    lane_t              hi_lane;
    logic [DATA_W-1:0]  rdata_q;

    assign req_in = '{mode:  decode_mode(mode_cfg),
                      kind:  classify(req_fetch, req_write),
                      addr:  req_addr,
                      wdata: req_wdata};

    xmb_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .busy      (busy),
        .phase     (phase),
        .cur       (cur),
        .done      (rsp_done)
    );

    xmb_lanes u_lanes (
        .busy    (busy),
        .phase   (phase),
        .cur     (cur),
        .lo_lane (lo_lane),
        .hi_lane (hi_lane)
    );

    xmb_strobe u_strobe (
        .busy   (busy),
        .phase  (phase),
        .kind   (cur.kind),
        .ale    (ale),
        .psen_n (psen_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n)
    );

    // capture the byte on the data port at the edge closing the last phase
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (busy && (phase == PH_LAST) && (cur.kind != K_WRITE)) begin
            rdata_q <= data_on_hi(cur.mode) ? hi_port_i : lo_port_i;
        end
    end

    assign req_ready  = !busy;
    assign rsp_rdata  = rdata_q;
    assign lo_port_o  = lo_lane.val;
    assign lo_port_oe = lo_lane.oe;
    assign hi_port_o  = hi_lane.val;
    assign hi_port_oe = hi_lane.oe;

endmodule

// File: rtl/xmb_chk.sv
module xmb_chk
    import xmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_ready,
    input  logic [DATA_W-1:0]   rsp_rdata,
    input  logic                rsp_done,
    input  logic [DATA_W-1:0]   lo_port_o,
    input  logic                lo_port_oe,
    input  logic [DATA_W-1:0]   hi_port_o,
    input  logic                hi_port_oe,
    input  logic                ale,
    input  logic                psen_n,
    input  logic                rd_n,
    input  logic                wr_n
);

    a_r1_accept_ale: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (ale && !req_ready));

    a_r5_ale_single: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    a_r5_ports_hold: assert property (@(posedge clk) disable iff (rst)
        ale |=> ($stable(lo_port_o) && $stable(hi_port_o) &&
                 $stable(lo_port_oe) && $stable(hi_port_oe)));

    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);

    a_r6_ale_quiet: assert property (@(posedge clk) disable iff (rst)
        ale |-> (psen_n && rd_n && wr_n));

    a_r7_read_release: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !psen_n) |-> (lo_port_oe ^ hi_port_oe));

    a_r7_write_drive: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (lo_port_oe && hi_port_oe));

    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(rsp_rdata) |-> rsp_done);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r8_done_ready: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> req_ready);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!ale && psen_n && rd_n && wr_n && !lo_port_oe && !hi_port_oe));

endmodule

bind xmb_bus xmb_chk u_chk (.*);

// File: tb/tb_xmb_bus.sv
module tb_xmb_bus;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_cfg = 2'b00;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_fetch = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [7:0]  lo_port_o;
    logic        lo_port_oe;
    logic [7:0]  lo_port_i = '0;
    logic [7:0]  hi_port_o;
    logic        hi_port_oe;
    logic [7:0]  hi_port_i = '0;
    logic        ale, psen_n, rd_n, wr_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] exp_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmb_bus dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        if (m == 2'b01) return "R3";
        if (m == 2'b10) return "R4";
        return "R2";
    endfunction

    // expected {oe, value} of one port in one phase
    function automatic logic [8:0] exp_lane(input logic [1:0] m, input bit wr, input logic [15:0] a,
                                            input logic [7:0] wd, input int p, input bit hi);
        logic [8:0] dat;
        bit ap;
        ap  = (p < 2);
        dat = wr ? {1'b1, wd} : 9'h000;
        case (m)
            2'b01:   return hi ? {1'b1, (ap ? a[7:0] : a[15:8])} : (ap ? 9'h000 : dat);
            2'b10:   return hi ? (ap ? {1'b1, a[15:8]} : dat) : {1'b1, a[7:0]};
            default: return hi ? {1'b1, a[15:8]} : (ap ? {1'b1, a[7:0]} : dat);
        endcase
    endfunction

    task automatic do_access(input logic [1:0] m, input bit f, input bit w, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] rd2, input logic [7:0] rd3,
                             input bit chg);
        bit eff_w;
        bit dhi;
        logic [7:0] v;
        eff_w = w && !f;
        dhi   = (m == 2'b10);
        chk(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
        mode_cfg  = m; req_fetch = f; req_write = w; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            if (p == 0) req_valid = 1'b0;
            chk(req_ready == 1'b0, "R1 busy during access", req_ready, 0);
            chk(ale == (p == 0), "R5 ale phase", ale, (p == 0));
            chk({lo_port_oe, lo_port_o} == exp_lane(m, eff_w, a, wd, p, 1'b0),
                {mode_tag(m), " R7 R9 low port"}, {lo_port_oe, lo_port_o}, exp_lane(m, eff_w, a, wd, p, 1'b0));
            chk({hi_port_oe, hi_port_o} == exp_lane(m, eff_w, a, wd, p, 1'b1),
                {mode_tag(m), " R7 R9 high port"}, {hi_port_oe, hi_port_o}, exp_lane(m, eff_w, a, wd, p, 1'b1));
            chk({psen_n, rd_n, wr_n} == ((p < 2) ? 3'b111 : (f ? 3'b011 : (w ? 3'b110 : 3'b101))),
                "R6 strobes", {psen_n, rd_n, wr_n},
                ((p < 2) ? 3'b111 : (f ? 3'b011 : (w ? 3'b110 : 3'b101))));
            if (p == 1 && chg) begin
                mode_cfg = ~m; req_addr = ~a; req_wdata = ~wd;
                req_fetch = ~f; req_write = ~w; req_valid = 1'b1;
            end
            if (p == 3) req_valid = 1'b0;
            v = (p == 3) ? rd3 : rd2;
            if (dhi) begin hi_port_i = v; lo_port_i = ~v; end
            else     begin lo_port_i = v; hi_port_i = ~v; end
        end
        @(negedge clk);
        if (!eff_w) exp_rd = rd3;
        chk(rsp_done == 1'b1, "R8 done pulse", rsp_done, 1);
        chk(req_ready == 1'b1, "R8 ready in done clock", req_ready, 1);
        chk(rsp_rdata == exp_rd, "R7 returned byte", rsp_rdata, exp_rd);
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(rsp_done == 1'b0, "R8 done lasts one clock", rsp_done, 0);
            chk(ale == 1'b0, "R9 busy request ignored", ale, 0);
            chk({psen_n, rd_n, wr_n, lo_port_oe, hi_port_oe} == 5'b11100, "R10 idle outputs",
                {psen_n, rd_n, wr_n, lo_port_oe, hi_port_oe}, 5'b11100);
            chk(rsp_rdata == exp_rd, "R7 byte held", rsp_rdata, exp_rd);
        end
    endtask

    initial begin
        int seed;
        seed = 32'h5a17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && ale == 1'b0, "R10 reset idle", {req_ready, ale}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk({psen_n, rd_n, wr_n} == 3'b111, "R10 reset strobes", {psen_n, rd_n, wr_n}, 3'b111);
        chk({lo_port_oe, hi_port_oe, lo_port_o, hi_port_o} == 18'h0, "R10 reset ports",
            {lo_port_oe, hi_port_oe, lo_port_o, hi_port_o}, 0);
        chk(rsp_done == 1'b0 && rsp_rdata == 8'h00, "R10 reset response", {rsp_done, rsp_rdata}, 0);

        // directed corner cases
        do_access(2'b00, 0, 1, 16'h12c4, 8'h3e, 8'h11, 8'h22, 0);   // write keeps rdata 0
        idle_gap(1);
        do_access(2'b00, 0, 0, 16'hbeef, 8'h00, 8'h5a, 8'ha5, 0);   // read samples last clock
        idle_gap(2);
        do_access(2'b11, 1, 0, 16'h0f80, 8'h00, 8'h01, 8'h7c, 0);   // mode 11 acts as plain
        idle_gap(1);
        do_access(2'b01, 0, 1, 16'h8421, 8'hc3, 8'h00, 8'h00, 1);   // changes mid access
        idle_gap(2);
        do_access(2'b10, 1, 1, 16'hfe01, 8'h99, 8'h44, 8'h6d, 1);   // fetch wins over write
        do_access(2'b01, 0, 0, 16'h00ff, 8'h00, 8'h12, 8'h34, 0);   // back to back
        do_access(2'b10, 0, 1, 16'h5555, 8'hf0, 8'h00, 8'h00, 0);   // back to back
        idle_gap(1);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            do_access(2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 8'($urandom),
                      8'($urandom), 8'($urandom), ($urandom % 4) == 0);
            if (($urandom % 3) != 0) idle_gap(1 + ($urandom % 3));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule